// File: doc/BRIEF.md
# Board Control Register Bank

This block is a small memory-mapped register bank for a development board. A synchronous register bus (select, write enable, address, write data, registered read data) reaches it. It drives an 8-bit LED bar, an 8-character ASCII display, an 8-bit general-purpose output and a bit-banged I2C port, and it can raise a board reset request. The block decodes only the low 20 bits of the bus address. A 256-byte hole in that window belongs to a UART that lives outside this block.

The display can be loaded in two ways. A whole data word can be written, and the block shows it as uppercase hexadecimal digits with the most significant nibble in the leftmost position. Single characters can also be written, one per aligned address, 8 bytes apart. When the I2C input register is read, the live data line from the slave appears in bit 0.

Register offsets within the 20-bit window: LED 0x00008, hex word 0x00410, characters 0x00418 + 8·i (i = 0..7, position 0 leftmost), reset request 0x00500, general output 0x00A00, I2C input 0x00B00, I2C output enable 0x00B08, I2C output 0x00B10, I2C select 0x00B18. Any other offset is an exact miss.

Top module: `board_ctrl_regs`

## Requirements
- R1: Only bus_addr[19:0] selects a register. Addresses that differ only above bit 19 reach the same register.
- R2: A write to 0x00008 stores wdata[7:0] on led_bar, with bit 7 the leftmost LED. A read of 0x00008 returns it zero-extended.
- R3: A write to 0x00410 sets display position i (disp_chars[8i+7:8i]) to the uppercase ASCII hex digit of nibble wdata[31-4i:28-4i], for all eight positions.
- R4: A write to 0x00418 + 8·i (i in 0..7) sets position i to wdata[7:0] and leaves the other positions unchanged.
- R5: Writes to 0x00A00, 0x00B08 and 0x00B18 store wdata[7:0] on gpo, wdata[1:0] on i2c_oe and wdata[0] on i2c_sel. Each of these reads back zero-extended.
- R6: A write to 0x00B10 drives i2c_scl_o from wdata[1] and i2c_sda_o from wdata[0] starting the next cycle. The pins hold until the next such write.
- R7: A read of 0x00B00 returns bit 1 equal to the last SCL value written, bit 0 equal to i2c_sda_i in the read cycle, and all other bits zero.
- R8: A write to 0x00500 makes board_rst_req high for exactly the following cycle.
- R9: While rst_n is low, all eight display positions are 0x20 (space) and every other register and output is zero.
- R10: An access in 0x00900..0x009FF changes no state, reads zero and does not raise bad_addr.
- R11: An access to any other undecoded offset (including an unaligned or out-of-range character address) reads zero, changes no state, and raises bad_addr for the following cycle only.
- R12: bus_rdata is registered. It shows the read value in the cycle after a read select and is zero in the cycle after any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; low 20 bits decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| i2c_sda_i | input | 1 | Data line driven by the I2C slave |
| led_bar | output | 8 | LED bar, bit 7 leftmost |
| disp_chars | output | NCHAR*8 | Display characters, position 0 in bits 7:0 |
| gpo | output | 8 | General-purpose output |
| i2c_scl_o | output | 1 | I2C clock line |
| i2c_sda_o | output | 1 | I2C data line |
| i2c_oe | output | 2 | I2C output enables |
| i2c_sel | output | 1 | I2C port select |
| board_rst_req | output | 1 | One-cycle board reset request |
| bad_addr | output | 1 | One-cycle undecoded-access flag |

## Verification
The bench builds the block with its defaults: ADDR_W = 32, DATA_W = 32, NCHAR = 8. With 12 address bits above the window, aliased accesses can reach every register, so R1 can be exercised. With eight positions and 32-bit data, every position receives a hex digit, and the character offset just past the last position (0x00458) works as an out-of-range miss. Keeping i2c_sda_i moving between reads shows that bit 0 of the input register follows the live line and not a stored copy.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int WIN_W = 20;

  typedef enum logic [3:0] {
    RK_NONE, RK_HOLE, RK_LED, RK_HEXW, RK_CHAR, RK_SWRST,
    RK_GPO, RK_I2CIN, RK_I2COE, RK_I2COUT, RK_I2CSEL
  } reg_kind_e;

  localparam logic [WIN_W-1:0] OFF_LED    = 20'h00008;
  localparam logic [WIN_W-1:0] OFF_HEXW   = 20'h00410;
  localparam logic [WIN_W-1:0] CHAR_BASE  = 20'h00418;
  localparam logic [WIN_W-1:0] OFF_SWRST  = 20'h00500;
  localparam logic [WIN_W-1:0] HOLE_LO    = 20'h00900;
  localparam logic [WIN_W-1:0] HOLE_HI    = 20'h009FF;
  localparam logic [WIN_W-1:0] OFF_GPO    = 20'h00A00;
  localparam logic [WIN_W-1:0] OFF_I2CIN  = 20'h00B00;
  localparam logic [WIN_W-1:0] OFF_I2COE  = 20'h00B08;
  localparam logic [WIN_W-1:0] OFF_I2COUT = 20'h00B10;
  localparam logic [WIN_W-1:0] OFF_I2CSEL = 20'h00B18;

  localparam logic [7:0] SPACE_CH = 8'h20;

  // Uppercase ASCII hex digit for one nibble
  function automatic logic [7:0] hex_char(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction
endpackage

// File: rtl/brd_decode.sv
module brd_decode
  import brd_pkg::*;
#(
  parameter int NCHAR = 8,
  localparam int IDX_W = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
  input  logic [WIN_W-1:0] off,
  output reg_kind_e        kind,
  output logic [IDX_W-1:0] char_idx
);
  logic [WIN_W-1:0] rel;
  logic             char_hit;

  assign rel      = off - CHAR_BASE;
  assign char_hit = (off >= CHAR_BASE) && (rel[2:0] == 3'b000) &&
                    ((rel >> 3) < WIN_W'(NCHAR));
  assign char_idx = rel[IDX_W+2:3];

  always_comb begin
    kind = RK_NONE;
    if (off >= HOLE_LO && off <= HOLE_HI) begin
      kind = RK_HOLE;
    end else if (char_hit) begin
      kind = RK_CHAR;
    end else begin
      case (off)
        OFF_LED:    kind = RK_LED;
        OFF_HEXW:   kind = RK_HEXW;
        OFF_SWRST:  kind = RK_SWRST;
        OFF_GPO:    kind = RK_GPO;
        OFF_I2CIN:  kind = RK_I2CIN;
        OFF_I2COE:  kind = RK_I2COE;
        OFF_I2COUT: kind = RK_I2COUT;
        OFF_I2CSEL: kind = RK_I2CSEL;
        default:    kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/brd_display.sv
module brd_display
  import brd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NCHAR  = 8,
  localparam int IDX_W   = (NCHAR > 1) ? $clog2(NCHAR) : 1,
  localparam int HEX_DIG = DATA_W / 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hex,
  input  logic               wr_char,
  input  logic [IDX_W-1:0]   char_idx,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NCHAR*8-1:0] chars
);
  logic [7:0] pos_q [NCHAR];

  for (genvar i = 0; i < NCHAR; i++) begin : g_pos
    logic [7:0] hex_c;
    if (i < HEX_DIG) begin : g_dig
      assign hex_c = hex_char(wdata[DATA_W-1-4*i -: 4]);
    end else begin : g_pad
      assign hex_c = SPACE_CH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   pos_q[i] <= SPACE_CH;
      else if (wr_hex)                              pos_q[i] <= hex_c;
      else if (wr_char && char_idx == IDX_W'(i))    pos_q[i] <= wdata[7:0];
    end

    assign chars[i*8 +: 8] = pos_q[i];

    // R4: a character write lands in its own position
    a_r4_char_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_char && char_idx == IDX_W'(i)) |=> (chars[i*8 +: 8] == $past(wdata[7:0])));
  end

  // R3: after a word write the last position holds an uppercase hex digit
  a_r3_hex_upper: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hex |=> ((chars[NCHAR*8-1 -: 8] >= 8'h30 && chars[NCHAR*8-1 -: 8] <= 8'h39) ||
                (chars[NCHAR*8-1 -: 8] >= 8'h41 && chars[NCHAR*8-1 -: 8] <= 8'h46) ||
                (chars[NCHAR*8-1 -: 8] == SPACE_CH)));
endmodule

// File: rtl/brd_i2c.sv
module brd_i2c (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_out,
  input  logic       wr_oe,
  input  logic       wr_sel,
  input  logic [1:0] wbits,
  output logic       scl_o,
  output logic       sda_o,
  output logic [1:0] oe,
  output logic       sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_o <= 1'b0;
      sda_o <= 1'b0;
      oe    <= 2'b00;
      sel   <= 1'b0;
    end else begin
      if (wr_out) begin
        scl_o <= wbits[1];
        sda_o <= wbits[0];
      end
      if (wr_oe)  oe  <= wbits;
      if (wr_sel) sel <= wbits[0];
    end
  end

  // R6: the pins move only after a write to the output register
  a_r6_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_out) |-> $stable({scl_o, sda_o}));
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import brd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NCHAR  = 8,
  localparam int IDX_W = (NCHAR > 1) ? $clog2(NCHAR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               i2c_sda_i,
  output logic [7:0]         led_bar,
  output logic [NCHAR*8-1:0] disp_chars,
  output logic [7:0]         gpo,
  output logic               i2c_scl_o,
  output logic               i2c_sda_o,
  output logic [1:0]         i2c_oe,
  output logic               i2c_sel,
  output logic               board_rst_req,
  output logic               bad_addr
);
  logic [WIN_W-1:0] off;
  logic             unused_hi;
  reg_kind_e        kind;
  logic [IDX_W-1:0] char_idx;
  logic             wr_en, rd_en;
  logic             wr_swrst, miss;
  logic [DATA_W-1:0] rd_mux;

  assign off       = bus_addr[WIN_W-1:0];
  assign unused_hi = ^bus_addr[ADDR_W-1:WIN_W];
  assign wr_en     = bus_sel && bus_we;
  assign rd_en     = bus_sel && !bus_we;
  assign wr_swrst  = wr_en && (kind == RK_SWRST);
  assign miss      = bus_sel && (kind == RK_NONE);

  brd_decode #(.NCHAR(NCHAR)) u_dec (
    .off(off), .kind(kind), .char_idx(char_idx)
  );

  brd_display #(.DATA_W(DATA_W), .NCHAR(NCHAR)) u_disp (
    .clk(clk), .rst_n(rst_n),
    .wr_hex(wr_en && kind == RK_HEXW),
    .wr_char(wr_en && kind == RK_CHAR),
    .char_idx(char_idx), .wdata(bus_wdata), .chars(disp_chars)
  );

  brd_i2c u_i2c (
    .clk(clk), .rst_n(rst_n),
    .wr_out(wr_en && kind == RK_I2COUT),
    .wr_oe(wr_en && kind == RK_I2COE),
    .wr_sel(wr_en && kind == RK_I2CSEL),
    .wbits(bus_wdata[1:0]),
    .scl_o(i2c_scl_o), .sda_o(i2c_sda_o), .oe(i2c_oe), .sel(i2c_sel)
  );

  always_comb begin
    rd_mux = '0;
    case (kind)
      RK_LED:    rd_mux[7:0] = led_bar;
      RK_GPO:    rd_mux[7:0] = gpo;
      RK_I2CIN:  rd_mux[1:0] = {i2c_scl_o, i2c_sda_i};
      RK_I2COE:  rd_mux[1:0] = i2c_oe;
      RK_I2CSEL: rd_mux[0]   = i2c_sel;
      default:   rd_mux      = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_bar       <= '0;
      gpo           <= '0;
      board_rst_req <= 1'b0;
      bad_addr      <= 1'b0;
      bus_rdata     <= '0;
    end else begin
      if (wr_en && kind == RK_LED) led_bar <= bus_wdata[7:0];
      if (wr_en && kind == RK_GPO) gpo     <= bus_wdata[7:0];
      board_rst_req <= wr_swrst;
      bad_addr      <= miss;
      bus_rdata     <= rd_en ? rd_mux : '0;
    end
  end

  // R8: a reset request only follows a write to its register
  a_r8_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_req |-> $past(wr_swrst));
  // R11: the bad flag only follows an undecoded access
  a_r11_bad_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> $past(miss));
  // R10: the UART hole stays silent
  a_r10_hole_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && kind == RK_HOLE) |=> (!bad_addr && bus_rdata == '0));
  // R12: no read in the previous cycle means zero read data
  a_r12_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_board_ctrl_regs.sv
module sim_board_ctrl_regs;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NCHAR  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0, i2c_sda_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [7:0] led_bar, gpo;
  logic [NCHAR*8-1:0] disp_chars;
  logic i2c_scl_o, i2c_sda_o, i2c_sel, board_rst_req, bad_addr;
  logic [1:0] i2c_oe;

  board_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCHAR(NCHAR)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .i2c_sda_i(i2c_sda_i), .led_bar(led_bar), .disp_chars(disp_chars),
    .gpo(gpo), .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o),
    .i2c_oe(i2c_oe), .i2c_sel(i2c_sel), .board_rst_req(board_rst_req),
    .bad_addr(bad_addr)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_led, m_gpo, m_ch [NCHAR];
  logic [1:0]  m_oe;
  logic        m_sel, m_scl, m_sda, m_rst, m_bad;
  logic [31:0] m_rd;

  function automatic bit is_known(input int o);
    if (o == 'h8 || o == 'h410 || o == 'h500 || o == 'hA00 || o == 'hB00 ||
        o == 'hB08 || o == 'hB10 || o == 'hB18) return 1;
    return (o >= 'h418) && (o < 'h418 + 8 * NCHAR) && (o % 8 == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_led <= 0; m_gpo <= 0; m_oe <= 0; m_sel <= 0; m_scl <= 0; m_sda <= 0;
      m_rst <= 0; m_bad <= 0; m_rd <= 0;
      for (int k = 0; k < NCHAR; k++) m_ch[k] <= 8'h20;
    end else begin
      int o;
      o = int'(bus_addr % 32'h100000);
      m_rst <= 0; m_bad <= 0; m_rd <= 0;
      if (bus_sel && !(o >= 'h900 && o <= 'h9FF)) begin
        if (!is_known(o)) m_bad <= 1;
        else if (bus_we) begin
          if (o == 'h8)   m_led <= bus_wdata[7:0];
          if (o == 'hA00) m_gpo <= bus_wdata[7:0];
          if (o == 'hB08) m_oe  <= bus_wdata[1:0];
          if (o == 'hB18) m_sel <= bus_wdata[0];
          if (o == 'hB10) begin m_scl <= bus_wdata[1]; m_sda <= bus_wdata[0]; end
          if (o == 'h500) m_rst <= 1;
          if (o == 'h410)
            for (int k = 0; k < NCHAR; k++) begin
              int d;
              d = int'((bus_wdata >> (28 - 4 * k)) & 32'hF);
              m_ch[k] <= (d < 10) ? 8'(48 + d) : 8'(65 + d - 10);
            end
          if (o >= 'h418 && o < 'h418 + 8 * NCHAR) m_ch[(o - 'h418) / 8] <= bus_wdata[7:0];
        end else begin
          if (o == 'h8)   m_rd <= {24'h0, m_led};
          if (o == 'hA00) m_rd <= {24'h0, m_gpo};
          if (o == 'hB08) m_rd <= {30'h0, m_oe};
          if (o == 'hB18) m_rd <= {31'h0, m_sel};
          if (o == 'hB00) m_rd <= {30'h0, m_scl, i2c_sda_i};
        end
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(led_bar == m_led, "R2 led_bar", led_bar, m_led);
      chk(gpo == m_gpo, "R5 gpo", gpo, m_gpo);
      chk(i2c_oe == m_oe && i2c_sel == m_sel, "R5 oe/sel", {i2c_oe, i2c_sel}, {m_oe, m_sel});
      chk(i2c_scl_o == m_scl && i2c_sda_o == m_sda, "R6 scl/sda", {i2c_scl_o, i2c_sda_o}, {m_scl, m_sda});
      chk(board_rst_req == m_rst, "R8 board_rst_req", board_rst_req, m_rst);
      chk(bad_addr == m_bad, "R11 bad_addr", bad_addr, m_bad);
      chk(bus_rdata == m_rd, "R12 R7 bus_rdata", bus_rdata, m_rd);
      for (int k = 0; k < NCHAR; k++)
        chk(disp_chars[k*8 +: 8] == m_ch[k], "R3 R4 display position", disp_chars[k*8 +: 8], m_ch[k]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic acc(input logic [31:0] a, input bit we, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int offs [18] = '{'h8, 'h410, 'h418, 'h430, 'h450, 'h458, 'h419, 'h500, 'hA00,
                      'hB00, 'hB08, 'hB10, 'hB18, 'h900, 'h9F8, 'h0, 'hFFFF8, 'h414};
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(disp_chars == {NCHAR{8'h20}}, "R9 display spaces", disp_chars, {NCHAR{8'h20}});
    chk({led_bar, gpo, i2c_oe, i2c_sel, i2c_scl_o, i2c_sda_o, board_rst_req, bad_addr} == '0,
        "R9 registers zero", {led_bar, gpo}, 0);

    // R1: alias above bit 19
    acc(32'hFFF0_0008, 1, 32'h0000_00A5);
    acc(32'h0030_0008, 0, 0);
    idle();
    chk(bus_rdata == 32'hA5, "R1 alias readback", bus_rdata, 32'hA5);
    chk(led_bar == 8'hA5, "R2 led bits", led_bar, 8'hA5);

    // R3: hex word
    acc(32'h0000_0410, 1, 32'h1234_ABCD);
    idle();
    chk(disp_chars[7:0] == 8'h31, "R3 leftmost digit", disp_chars[7:0], 8'h31);
    chk(disp_chars[63:56] == 8'h44, "R3 rightmost digit D", disp_chars[63:56], 8'h44);

    // R4 / R11: last position, then one past it
    acc(32'h0000_0450, 1, 32'hFFFF_FF5A);
    acc(32'h0000_0458, 1, 32'h0000_0041);
    idle();
    chk(disp_chars[63:56] == 8'h5A, "R4 last position", disp_chars[63:56], 8'h5A);
    chk(bad_addr == 1'b1, "R11 out-of-range char flag", bad_addr, 1);
    idle();
    chk(bad_addr == 1'b0, "R11 flag one cycle", bad_addr, 0);

    // R10: UART hole
    acc(32'h0000_0900, 1, 32'hFFFF_FFFF);
    acc(32'h0000_09F8, 0, 0);
    idle();
    chk(bus_rdata == 0 && bad_addr == 0, "R10 hole quiet", {bus_rdata, bad_addr}, 0);

    // R7: live SDA in bit 0, last SCL in bit 1
    acc(32'h0000_0B10, 1, 32'h2);
    i2c_sda_i = 1'b1;
    acc(32'h0000_0B00, 0, 0);
    idle();
    chk(bus_rdata == 32'h3, "R7 sda high", bus_rdata, 3);
    i2c_sda_i = 1'b0;
    acc(32'h0000_0B00, 0, 0);
    idle();
    chk(bus_rdata == 32'h2, "R7 sda low", bus_rdata, 2);

    // R8: reset request pulse
    acc(32'h0000_0500, 1, 0);
    idle();
    chk(board_rst_req == 1'b1, "R8 pulse high", board_rst_req, 1);
    idle();
    chk(board_rst_req == 1'b0, "R8 pulse ends", board_rst_req, 0);

    // Mixed traffic compared cycle by cycle
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      a = {$urandom_range(0, 4095), 20'(offs[$urandom_range(0, 17)])};
      i2c_sda_i = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) idle();
      else acc(a, $urandom_range(0, 1), $urandom);
    end
    idle();

    // R9: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(disp_chars == {NCHAR{8'h20}}, "R9 display after reset", disp_chars, {NCHAR{8'h20}});
    chk({led_bar, gpo} == '0, "R9 led/gpo after reset", {led_bar, gpo}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    report();
  end
endmodule